// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block is a byte-level I2C master. The host drives it with a byte-load strobe, a stop request and a repeated-start enable. Loading a byte while the block is idle is what opens a transaction. The block waits until the bus is free, forms a start condition and shifts the byte out as the slave address. After each byte it clocks a ninth pulse and samples the acknowledge. It then raises an interrupt flag and holds SCL low until the host acts again.

In that held state the host has three choices. It can load another byte, which is sent as plain data. It can load a byte with the repeated-start enable set, so that a repeated start comes before the byte. Or it can request a stop condition. Both bus lines are open-drain: an `_oe` output of 1 pulls the line low. A bus monitor watches the real line levels and keeps a bus-busy flag, so transfers by other masters also hold off a new start. Arbitration and clock stretching are not handled.

The state machine has nine states:
- `S_IDLE`: lines released.
- `S_STA`: SDA low with SCL high, which forms a start.
- `S_BLO` and `S_BHI`: the low and high halves of one bit.
- `S_HOLD`: SCL held low between bytes.
- `S_RSA` and `S_RSB`: SDA released, first with SCL low and then with SCL high, before a repeated start.
- `S_SPA` and `S_SPB`: SDA low, first with SCL low and then with SCL high, before the stop.

The transitions are:
- `S_IDLE`→`S_STA` when a byte is pending and the bus is free.
- `S_STA`→`S_BLO` on a tick.
- `S_BLO`→`S_BHI` on a tick.
- `S_BHI`→`S_BLO` on a tick, or `S_BHI`→`S_HOLD` on the tick that ends the ninth clock.
- `S_HOLD`→`S_SPA` on a stop request.
- `S_HOLD`→`S_RSA` on a load with the repeated-start enable set.
- `S_HOLD`→`S_BLO` on a load without it.
- `S_RSA`→`S_RSB`→`S_STA`, and `S_SPA`→`S_SPB`→`S_IDLE`, each step on a tick.

A tick comes every `presc`+1 clock cycles, and `presc` must be at least 1.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset `scl_oe`, `sda_oe`, `irq`, `bus_busy` and `master_on` are all 0, so both lines are released.
- R2: A `wr_data` strobe while idle and the bus is free produces a start condition (SDA falls while SCL stays high). It is followed by the byte, most significant bit first, one bit per SCL pulse, and then a ninth pulse with SDA released.
- R3: While a byte is being clocked, every SCL high phase and every SCL low phase between bit pulses lasts `presc`+1 clock cycles.
- R4: SDA changes while SCL is high only to form a start, a repeated start or a stop.
- R5: At the end of the ninth SCL pulse `irq` becomes 1. `ack_ok` becomes 1 if SDA was low during that pulse and 0 if it was high.
- R6: After the ninth pulse SCL stays low and `master_on` stays 1 until the host loads a byte or requests a stop. A load with `rstart_en`=0 sends the byte with no start condition. An accepted load or stop clears `irq`.
- R7: A `stop_req` strobe while waiting between bytes produces a stop condition. The sequence is SDA low, then SCL released, then SDA released. Afterwards both lines are free and `master_on` is 0.
- R8: A load while waiting between bytes with `rstart_en`=1 produces a repeated start with no stop, and then sends the byte.
- R9: `bus_busy` becomes 1 after any start condition on the lines, including one formed by another master, and returns to 0 after a stop condition.
- R10: A byte loaded while idle and `bus_busy`=1 is held: neither line is driven until `bus_busy` clears. Then the start and the byte follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 1 | One-cycle strobe: load `wr_byte` |
| wr_byte | input | BYTE_W | Byte to transmit (address or data) |
| stop_req | input | 1 | One-cycle strobe: finish with a stop condition |
| rstart_en | input | 1 | When 1, a load between bytes starts with a repeated start |
| presc | input | PRESC_W | Half SCL period minus one, in clock cycles (at least 1) |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Set after the ninth clock of each byte |
| ack_ok | output | 1 | Acknowledge seen on the last ninth clock |
| bus_busy | output | 1 | A start has been seen on the bus and no stop since |
| master_on | output | 1 | Controller is running a transaction |

## Verification
All 256 byte values are sent through the same transaction, with the slave model's acknowledge following a mod-3 pattern. This separates bit-order and shift faults from acknowledge-sampling faults. Three prescaler settings are used, so that a fixed or off-by-one phase length shows up in the measured SCL high and low runs. Separate scenarios then cover a repeated-start load against a plain data load, a stop request, and a load made while another master holds the bus busy. Start and stop events are counted on the lines, so an extra or missing start, repeated start or stop is seen.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_STA,
        S_BLO,
        S_BHI,
        S_HOLD,
        S_RSA,
        S_RSB,
        S_SPA,
        S_SPB
    } state_t;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               clr,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt;

    assign tick = run && (cnt == presc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic busy
);
    logic [SYNC_N-1:0] scl_q;
    logic [SYNC_N-1:0] sda_q;
    logic              sda_p;
    logic              scl_s;
    logic              saw_start;
    logic              saw_stop;

    assign scl_s     = scl_q[SYNC_N-1];
    assign sda_s     = sda_q[SYNC_N-1];
    assign saw_start = scl_s && sda_p && !sda_s;
    assign saw_stop  = scl_s && !sda_p && sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            sda_p <= 1'b1;
            busy  <= 1'b0;
        end else begin
            scl_q <= {scl_q[SYNC_N-2:0], scl_in};
            sda_q <= {sda_q[SYNC_N-2:0], sda_in};
            sda_p <= sda_s;
            if (saw_start) begin
                busy <= 1'b1;
            end else if (saw_stop) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2cm_txpath.sv
module i2cm_txpath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] load_val,
    output logic         tx_bit,
    output logic         ack_slot
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    assign tx_bit   = sh[W-1];
    assign ack_slot = (cnt == CW'(W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (load) begin
            sh  <= load_val;
            cnt <= '0;
        end else if (adv) begin
            sh  <= {sh[W-2:0], 1'b0};
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
    parameter int PRESC_W = 8,
    parameter int BYTE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_data,
    input  logic [BYTE_W-1:0]  wr_byte,
    input  logic               stop_req,
    input  logic               rstart_en,
    input  logic [PRESC_W-1:0] presc,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic               irq,
    output logic               ack_ok,
    output logic               bus_busy,
    output logic               master_on
);
    import i2cm_pkg::*;

    state_t state;
    state_t state_n;
    logic   pend;
    logic   tick;
    logic   sda_s;
    logic   tx_bit;
    logic   ack_slot;
    logic   accept_wr;
    logic   adv;
    logic   hold_exit;
    logic   ninth_done;

    assign accept_wr  = wr_data && ((state == S_IDLE) || (state == S_HOLD && !stop_req));
    assign adv        = (state == S_BHI) && tick && !ack_slot;
    assign ninth_done = (state == S_BHI) && tick && ack_slot;
    assign hold_exit  = (state == S_HOLD) && (state_n != S_HOLD);
    assign master_on  = (state != S_IDLE);

    i2cm_tick #(.PRESC_W(PRESC_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (master_on),
        .clr   (hold_exit),
        .presc (presc),
        .tick  (tick)
    );

    i2cm_busmon #(.SYNC_N(2)) u_busmon (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .sda_s  (sda_s),
        .busy   (bus_busy)
    );

    i2cm_txpath #(.W(BYTE_W)) u_txpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept_wr),
        .adv      (adv),
        .load_val (wr_byte),
        .tx_bit   (tx_bit),
        .ack_slot (ack_slot)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // pending load, interrupt flag and acknowledge status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            irq    <= 1'b0;
            ack_ok <= 1'b0;
        end else begin
            if (state != S_IDLE) begin
                pend <= 1'b0;
            end else if (wr_data) begin
                pend <= 1'b1;
            end
            if (ninth_done) begin
                irq    <= 1'b1;
                ack_ok <= !sda_s;
            end else if (state == S_HOLD && (stop_req || wr_data)) begin
                irq <= 1'b0;
            end
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: if (pend && !bus_busy) state_n = S_STA;
            S_STA:  if (tick) state_n = S_BLO;
            S_BLO:  if (tick) state_n = S_BHI;
            S_BHI:  if (tick) state_n = ack_slot ? S_HOLD : S_BLO;
            S_HOLD: begin
                if (stop_req) begin
                    state_n = S_SPA;
                end else if (wr_data) begin
                    state_n = rstart_en ? S_RSA : S_BLO;
                end
            end
            S_RSA:  if (tick) state_n = S_RSB;
            S_RSB:  if (tick) state_n = S_STA;
            S_SPA:  if (tick) state_n = S_SPB;
            S_SPB:  if (tick) state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // line drivers
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            S_IDLE: begin scl_oe = 1'b0; sda_oe = 1'b0; end
            S_STA:  begin scl_oe = 1'b0; sda_oe = 1'b1; end
            S_BLO:  begin scl_oe = 1'b1; sda_oe = !ack_slot && !tx_bit; end
            S_BHI:  begin scl_oe = 1'b0; sda_oe = !ack_slot && !tx_bit; end
            S_HOLD: begin scl_oe = 1'b1; sda_oe = 1'b0; end
            S_RSA:  begin scl_oe = 1'b1; sda_oe = 1'b0; end
            S_RSB:  begin scl_oe = 1'b0; sda_oe = 1'b0; end
            S_SPA:  begin scl_oe = 1'b1; sda_oe = 1'b1; end
            S_SPB:  begin scl_oe = 1'b0; sda_oe = 1'b1; end
            default: begin scl_oe = 1'b0; sda_oe = 1'b0; end
        endcase
    end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
    input logic             clk,
    input logic             rst_n,
    input i2cm_pkg::state_t st,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             irq,
    input logic             bus_busy
);
    import i2cm_pkg::*;

    // R4: SDA pulled low while SCL stays released only when forming a start
    a_r4_sda_fall_only_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && $rose(sda_oe)) |-> (st == S_STA));

    // R4: SDA released while SCL stays released only when forming a stop
    a_r4_sda_rise_only_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && $fell(sda_oe)) |-> ($past(st) == S_SPB));

    // R5: interrupt rises only when a bit-high phase ends
    a_r5_irq_after_ninth: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(st) == S_BHI));

    // R6: SCL held low while waiting between bytes
    a_r6_scl_low_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HOLD) |-> scl_oe);

    // R10: a fresh start never begins while the bus is busy
    a_r10_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STA && $past(st) == S_IDLE) |-> !$past(bus_busy));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (state),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .irq      (irq),
    .bus_busy (bus_busy)
);

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_data = 1'b0;
    logic [7:0]    wr_byte = 8'h00;
    logic          stop_req = 1'b0;
    logic          rstart_en = 1'b0;
    logic [PW-1:0] presc = 8'd1;
    logic          scl_oe, sda_oe, irq, ack_ok, bus_busy, master_on;
    logic          ext_scl = 1'b0;
    logic          ext_sda = 1'b0;
    logic          slv_sda = 1'b0;
    logic          ack_en = 1'b1;
    logic          scl_w, sda_w;

    assign scl_w = !(scl_oe || ext_scl);
    assign sda_w = !(sda_oe || slv_sda || ext_sda);

    always #4 clk = ~clk;

    i2c_byte_master u_i2c_byte_master (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_byte(wr_byte),
        .stop_req(stop_req), .rstart_en(rstart_en), .presc(presc),
        .scl_in(scl_w), .sda_in(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .irq(irq), .ack_ok(ack_ok), .bus_busy(bus_busy), .master_on(master_on)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // slave / line monitor state
    logic       p_scl = 1'b1, p_sda = 1'b1;
    int         bitn = 0;
    logic [7:0] sh = 8'h00;
    logic [7:0] rx_byte = 8'h00;
    int         rx_cnt = 0, starts = 0, stops = 0;
    int         hi_len = 0, lo_len = 0, len_bad = 0, len_seen = 0;

    always @(posedge clk) begin
        p_scl <= scl_w;
        p_sda <= sda_w;
        if (scl_w) hi_len <= p_scl ? hi_len + 1 : 1;
        else       lo_len <= !p_scl ? lo_len + 1 : 1;
        if (p_scl && scl_w && p_sda && !sda_w) begin
            starts <= starts + 1;
            bitn <= 0;
        end else if (p_scl && scl_w && !p_sda && sda_w) begin
            stops <= stops + 1;
            bitn <= 0;
        end else if (!p_scl && scl_w) begin
            if (bitn >= 1 && bitn <= 8) begin
                len_seen <= len_seen + 1;
                if (lo_len != int'(presc) + 1) len_bad <= len_bad + 1;
            end
            if (bitn < 8) begin
                sh <= {sh[6:0], sda_w};
                bitn <= bitn + 1;
            end else if (bitn == 8) begin
                bitn <= 9;
            end
        end else if (p_scl && !scl_w) begin
            if (bitn >= 1 && bitn <= 9) begin
                len_seen <= len_seen + 1;
                if (hi_len != int'(presc) + 1) len_bad <= len_bad + 1;
            end
            if (bitn == 8) begin
                rx_byte <= sh;
                rx_cnt <= rx_cnt + 1;
                slv_sda <= ack_en;
            end else if (bitn == 9) begin
                slv_sda <= 1'b0;
                bitn <= 0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] v);
        @(negedge clk);
        wr_byte = v;
        wr_data = 1'b1;
        @(negedge clk);
        wr_data = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(req, int'(irq), 1);
    endtask

    task automatic send(input logic [7:0] v, input bit ack, input string req);
        ack_en = ack;
        load(v);
        chk("R6 irq cleared by load", int'(irq), 0);
        wait_irq(req);
        chk("R2 byte MSB first", int'(rx_byte), int'(v));
        chk("R5 ack status", int'(ack_ok), int'(ack));
    endtask

    task automatic do_stop();
        int n = 0;
        @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk("R6 irq cleared by stop", int'(irq), 0);
        while (master_on && n < 2000) begin
            @(negedge clk);
            n++;
        end
        idle(6);
        chk("R7 master off after stop", int'(master_on), 0);
        chk("R7 lines released", int'(scl_w && sda_w), 1);
        chk("R9 busy cleared by stop", int'(bus_busy), 0);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 scl_oe", int'(scl_oe), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 bus_busy", int'(bus_busy), 0);
        chk("R1 master_on", int'(master_on), 0);

        // Phase A: address then sweep of all byte values, presc = 1
        presc = 8'd1;
        send(8'hA4, 1'b1, "R5 irq after address");
        chk("R2 one start", starts, 1);
        chk("R9 busy after own start", int'(bus_busy), 1);
        for (int v = 0; v < 256; v++) begin
            send(8'(v), (v % 3) != 0, "R5 irq after data");
            idle(3 * (int'(presc) + 1) + 4);
            chk("R6 SCL held low between bytes", int'(scl_w), 0);
            chk("R6 still master", int'(master_on), 1);
        end
        chk("R6 no extra start on plain loads", starts, 1);
        do_stop();
        chk("R7 one stop", stops, 1);
        chk("R4 start count", starts, 1);
        chk("R3 phase lengths presc 1", len_bad, 0);

        // Phase B: repeated start, presc = 4
        presc = 8'd4;
        send(8'h5A, 1'b1, "R5 irq after address");
        rstart_en = 1'b1;
        send(8'h3C, 1'b1, "R8 irq after restart byte");
        rstart_en = 1'b0;
        chk("R8 repeated start seen", starts, 3);
        chk("R8 no stop before repeated start", stops, 1);
        do_stop();
        chk("R7 stop count", stops, 2);
        chk("R3 phase lengths presc 4", len_bad, 0);

        // Phase C: another master holds the bus
        @(negedge clk);
        ext_sda = 1'b1;
        idle(10);
        chk("R9 busy from other master", int'(bus_busy), 1);
        ack_en = 1'b1;
        load(8'h81);
        idle(100);
        chk("R10 SDA not driven while busy", int'(sda_oe), 0);
        chk("R10 SCL not driven while busy", int'(scl_oe), 0);
        ext_sda = 1'b0;
        wait_irq("R10 deferred transfer completes");
        chk("R10 deferred byte", int'(rx_byte), 8'h81);
        chk("R10 start after free", starts, 5);
        do_stop();
        chk("R9 stop count with other master", stops, 4);

        // Phase D: no acknowledge, presc = 6
        presc = 8'd6;
        send(8'hC3, 1'b0, "R5 irq after nak");
        do_stop();
        chk("R4 final start count", starts, 6);
        chk("R4 final stop count", stops, 5);
        chk("R3 phase lengths presc 6", len_bad, 0);
        chk("R3 phases measured", int'(len_seen > 1000), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule